// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper for One H-Bridge

This block regulates the current in one motor winding by chopping the four gate enables of its H-bridge. Each chopping period opens with the two diagonal transistors that push current in the commanded direction. A digital sense value is compared against a target derived from a percentage level and a full-scale current. Once the blanking interval has passed and the sense value reaches the target, the drive phase ends and the bridge decays for a programmable number of clock cycles.

Three decay styles are supported. In the slow style only the active high-side transistor is released and the low-side one keeps conducting. In the fast style every gate is released. The mixed style starts fast for a fixed fraction of the off interval and then finishes slow. Every drive phase is preceded by an all-off dead interval, so the two transistors of a leg can never conduct together. The next period starts by itself once the off interval expires.

Top module: `phase_chopper`

## Requirements
- R1: While reset is asserted all four gates are low. Lowering `enable` forces all four gates low from the next clock cycle, and they stay low while `enable` stays low.
- R2: After `enable` rises, all gates stay low for exactly DEAD_CYC cycles. The drive pattern for the latched polarity then appears. Polarity 0 drives `gateSrcA` and `gateSinkB`; polarity 1 drives `gateSrcB` and `gateSinkA`.
- R3: Drive cycles are numbered from 0. The trip is ignored in drive cycles below `blankTime`. The drive phase ends after the first drive cycle whose index is at least `blankTime` and in which the trip condition holds. A drive phase therefore lasts max(blankTime, first trip cycle) + 1 cycles.
- R4: `tripThreshold` equals floor(min(levelPct,100) × tripMax / 100). The trip condition is `senseIn >= tripThreshold`, so a sense value one below the threshold never ends a drive phase.
- R5: Decay code 2'b00 or 2'b11 selects slow decay: only the sink gate of the active polarity stays high for the whole off interval. The off interval is `offTime` cycles, or 1 cycle when `offTime` is 0.
- R6: Decay code 2'b01 selects fast decay: all gates are low for the whole off interval.
- R7: Decay code 2'b10 selects mixed decay. All gates are low for floor(off interval × FAST_FRAC / 256) cycles. The active sink gate alone is then high for the rest of the off interval.
- R8: When the off interval expires, all gates are low for DEAD_CYC cycles. A new drive phase then starts with no outside action.
- R9: A polarity change during a drive phase or a dead interval starts a fresh DEAD_CYC all-off interval, which ends in the new drive pattern. A change during an off interval leaves that interval alone and takes effect at the next drive phase.
- R10: The source and sink gates of one leg are never high together. No gate rises unless all gates were low in the previous cycle.
- R11: `offTime` and `decayMode` are captured when the trip is accepted. `blankTime` is captured when a drive phase starts. Later changes to these inputs do not alter the phase already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low forces all gates off |
| polarity | input | 1 | Commanded current direction |
| decayMode | input | 2 | 00/11 slow, 01 fast, 10 mixed |
| levelPct | input | 7 | Target level in percent (values above 100 are treated as 100) |
| tripMax | input | CUR_W | Full-scale trip current |
| senseIn | input | CUR_W | Digitised winding current |
| offTime | input | TIME_W | Off interval in cycles (0 is treated as 1) |
| blankTime | input | TIME_W | Blanking cycles after each turn-on |
| gateSrcA | output | 1 | High-side gate, leg A |
| gateSinkA | output | 1 | Low-side gate, leg A |
| gateSrcB | output | 1 | High-side gate, leg B |
| gateSinkB | output | 1 | Low-side gate, leg B |
| tripThreshold | output | CUR_W | Computed trip threshold |

## Verification
Some properties are checked on every cycle by the assertions. These are leg exclusivity, the rule that any gate rise follows an all-off cycle, the diagonal pairing of each high-side gate with the opposite low-side gate, the forced-off response to `enable`, and the bound of the threshold by the full-scale value. The exact lengths need the bench's scenarios. These include the blanking-dependent drive length, the off intervals for each decay style, the fast/slow split of mixed decay, and the dead interval before each drive phase. The scenarios also cover polarity changes landing in different phases, the sense value one below the threshold, and parameters changed at the moments they are sampled.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEAD  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_DECAY = 2'd3
  } chopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDead;
    logic loadBlank;
    logic startOff;
    logic stepOff;
  } chopStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic deadDone;
    logic blankDone;
    logic tripHit;
    logic offDone;
    logic fastNow;
  } chopFlags_t;

  // gate vector order: {srcA, sinkA, srcB, sinkB}
  localparam logic [3:0] GATES_OFF = 4'b0000;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int CUR_W     = 10,
  parameter int TIME_W    = 8,
  parameter int DEAD_CYC  = 4,
  parameter int FAST_FRAC = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  chopStrobe_t       strobe,
  input  logic [6:0]        levelPct,
  input  logic [CUR_W-1:0]  tripMax,
  input  logic [CUR_W-1:0]  senseIn,
  input  logic [TIME_W-1:0] offTime,
  input  logic [TIME_W-1:0] blankTime,
  output chopFlags_t        flags,
  output logic [CUR_W-1:0]  threshold
);

  localparam int PCT_W  = 7;
  localparam int PROD_W = CUR_W + PCT_W;
  localparam int DEAD_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam int FRAC_W = 8;
  localparam int FLEN_W = TIME_W + FRAC_W;

  // threshold scaling
  logic [PCT_W-1:0]  pctClamp;
  logic [PROD_W-1:0] product;

  always_comb begin
    pctClamp  = (levelPct > PCT_W'(100)) ? PCT_W'(100) : levelPct;
    product   = PROD_W'(pctClamp) * PROD_W'(tripMax);
    threshold = CUR_W'(product / PROD_W'(100));
  end

  // dead-time counter
  logic [DEAD_W-1:0] deadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deadCnt <= '0;
    else if (strobe.loadDead) deadCnt <= DEAD_W'(DEAD_CYC - 1);
    else if (deadCnt != '0)   deadCnt <= deadCnt - DEAD_W'(1);
  end

  // blanking counter
  logic [TIME_W-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blankCnt <= '0;
    else if (strobe.loadBlank) blankCnt <= blankTime;
    else if (blankCnt != '0)   blankCnt <= blankCnt - TIME_W'(1);
  end

  // off-time counter with span captured at the trip
  logic [TIME_W-1:0] offCnt;
  logic [TIME_W-1:0] offSpan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt  <= '0;
      offSpan <= TIME_W'(1);
    end else if (strobe.startOff) begin
      offCnt  <= '0;
      offSpan <= (offTime == '0) ? TIME_W'(1) : offTime;
    end else if (strobe.stepOff) begin
      offCnt  <= offCnt + TIME_W'(1);
    end
  end

  logic [FLEN_W-1:0] fastProd;
  logic [FLEN_W-1:0] fastLen;

  always_comb begin
    fastProd        = FLEN_W'(offSpan) * FLEN_W'(FAST_FRAC);
    fastLen         = fastProd >> FRAC_W;
    flags.deadDone  = (deadCnt == '0);
    flags.blankDone = (blankCnt == '0);
    flags.tripHit   = (senseIn >= threshold);
    flags.offDone   = (offCnt == offSpan - TIME_W'(1));
    flags.fastNow   = (FLEN_W'(offCnt) < fastLen);
  end

endmodule

// File: rtl/chop_control.sv
module chop_control
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        polarity,
  input  logic [1:0]  decayMode,
  input  chopFlags_t  flags,
  output chopStrobe_t strobe,
  output logic [3:0]  gates
);

  chopState_t state, nextState;
  logic       polLat, latchPol;
  logic [1:0] modeLat;
  logic       latchMode;
  logic       keepSink;

  always_comb begin
    nextState = state;
    strobe    = '0;
    latchPol  = 1'b0;
    latchMode = 1'b0;
    if (!enable) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState       = ST_DEAD;
          strobe.loadDead = 1'b1;
          latchPol        = 1'b1;
        end
        ST_DEAD: begin
          if (polarity != polLat) begin
            strobe.loadDead = 1'b1;
            latchPol        = 1'b1;
          end else if (flags.deadDone) begin
            nextState        = ST_DRIVE;
            strobe.loadBlank = 1'b1;
          end
        end
        ST_DRIVE: begin
          if (polarity != polLat) begin
            nextState       = ST_DEAD;
            strobe.loadDead = 1'b1;
            latchPol        = 1'b1;
          end else if (flags.blankDone && flags.tripHit) begin
            nextState       = ST_DECAY;
            strobe.startOff = 1'b1;
            latchMode       = 1'b1;
          end
        end
        ST_DECAY: begin
          if (flags.offDone) begin
            nextState       = ST_DEAD;
            strobe.loadDead = 1'b1;
            latchPol        = 1'b1;
          end else begin
            strobe.stepOff  = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      polLat  <= 1'b0;
      modeLat <= 2'b00;
    end else begin
      state <= nextState;
      if (latchPol)  polLat  <= polarity;
      if (latchMode) modeLat <= decayMode;
    end
  end

  // gate decode from registered state: {srcA, sinkA, srcB, sinkB}
  always_comb begin
    keepSink = (modeLat == 2'b10) ? !flags.fastNow : (modeLat != 2'b01);
    gates    = GATES_OFF;
    if (state == ST_DRIVE) begin
      gates = polLat ? 4'b0110 : 4'b1001;
    end else if (state == ST_DECAY && keepSink) begin
      gates = polLat ? 4'b0100 : 4'b0001;
    end
  end

endmodule

// File: rtl/phase_chopper.sv
module phase_chopper
  import chop_pkg::*;
#(
  parameter int CUR_W     = 10,
  parameter int TIME_W    = 8,
  parameter int DEAD_CYC  = 4,
  parameter int FAST_FRAC = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              polarity,
  input  logic [1:0]        decayMode,
  input  logic [6:0]        levelPct,
  input  logic [CUR_W-1:0]  tripMax,
  input  logic [CUR_W-1:0]  senseIn,
  input  logic [TIME_W-1:0] offTime,
  input  logic [TIME_W-1:0] blankTime,
  output logic              gateSrcA,
  output logic              gateSinkA,
  output logic              gateSrcB,
  output logic              gateSinkB,
  output logic [CUR_W-1:0]  tripThreshold
);

  chopStrobe_t strobe;
  chopFlags_t  flags;
  logic [3:0]  gates;

  chop_datapath #(
    .CUR_W(CUR_W), .TIME_W(TIME_W), .DEAD_CYC(DEAD_CYC), .FAST_FRAC(FAST_FRAC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .levelPct(levelPct),
    .tripMax(tripMax), .senseIn(senseIn), .offTime(offTime),
    .blankTime(blankTime), .flags(flags), .threshold(tripThreshold)
  );

  chop_control control_i (
    .clk(clk), .rstN(rstN), .enable(enable), .polarity(polarity),
    .decayMode(decayMode), .flags(flags), .strobe(strobe), .gates(gates)
  );

  assign {gateSrcA, gateSinkA, gateSrcB, gateSinkB} = gates;

endmodule

// File: rtl/phase_chopper_chk.sv
module phase_chopper_chk #(
  parameter int CUR_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CUR_W-1:0] tripMax,
  input logic [CUR_W-1:0] tripThreshold,
  input logic             gateSrcA,
  input logic             gateSinkA,
  input logic             gateSrcB,
  input logic             gateSinkB
);

  logic [3:0] gv;
  assign gv = {gateSrcA, gateSinkA, gateSrcB, gateSinkB};

  assert_leg_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(gateSrcA && gateSinkA) && !(gateSrcB && gateSinkB));

  assert_rise_after_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateSrcA) || $rose(gateSinkA) || $rose(gateSrcB) || $rose(gateSinkB))
      |-> ($past(gv) == 4'b0000));

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (gv == 4'b0000));

  assert_diag_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    gateSrcA |-> gateSinkB);

  assert_diag_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    gateSrcB |-> gateSinkA);

  assert_threshold_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    tripThreshold <= tripMax);

endmodule

bind phase_chopper phase_chopper_chk #(.CUR_W(CUR_W)) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .tripMax(tripMax),
  .tripThreshold(tripThreshold), .gateSrcA(gateSrcA), .gateSinkA(gateSinkA),
  .gateSrcB(gateSrcB), .gateSinkB(gateSinkB)
);

// File: tb/phase_chopper_tb_top.sv
`timescale 1ns/1ps
module phase_chopper_tb_top;

  localparam int CUR_W = 10;
  localparam int TIME_W = 8;
  localparam int DEAD = 4;
  localparam int FRAC = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic polarity = 1'b0;
  logic [1:0] decayMode = 2'b00;
  logic [6:0] levelPct = 7'd50;
  logic [CUR_W-1:0] tripMax = 10'd1000;
  logic [CUR_W-1:0] senseIn = '0;
  logic [TIME_W-1:0] offTime = 8'd5;
  logic [TIME_W-1:0] blankTime = 8'd3;
  logic gateSrcA, gateSinkA, gateSrcB, gateSinkB;
  logic [CUR_W-1:0] tripThreshold;

  int vectors = 0;
  int fails = 0;
  int legViol = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase_chopper #(.CUR_W(CUR_W), .TIME_W(TIME_W), .DEAD_CYC(DEAD), .FAST_FRAC(FRAC)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .polarity(polarity), .decayMode(decayMode),
    .levelPct(levelPct), .tripMax(tripMax), .senseIn(senseIn), .offTime(offTime),
    .blankTime(blankTime), .gateSrcA(gateSrcA), .gateSinkA(gateSinkA),
    .gateSrcB(gateSrcB), .gateSinkB(gateSinkB), .tripThreshold(tripThreshold)
  );

  function automatic logic [3:0] gatesNow();
    return {gateSrcA, gateSinkA, gateSrcB, gateSinkB};
  endfunction

  function automatic logic [3:0] onPat(input logic p);
    return p ? 4'b0110 : 4'b1001;
  endfunction

  function automatic logic [3:0] sinkPat(input logic p);
    return p ? 4'b0100 : 4'b0001;
  endfunction

  function automatic int expThr(input int pct, input int mx);
    int pc;
    pc = (pct > 100) ? 100 : pct;
    return (pc * mx) / 100;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && ((gateSrcA && gateSinkA) || (gateSrcB && gateSinkB))) legViol++;
  end

  // count all-off samples until a non-zero pattern appears
  task automatic countZeros(output int zeros);
    zeros = 0;
    @(negedge clk);
    while (gatesNow() == 4'b0000 && zeros < 1000) begin
      zeros++;
      @(negedge clk);
    end
  endtask

  // one chopping period starting at drive cycle 0
  task automatic runPeriod(input int it, input logic pol, input int blankCur,
                           input int mode, input int off, input int tripAt,
                           input int newBlank, input logic newPol);
    int idx, expOn, offEff, fl, nExp, nAct, len, guard;
    int expPat[4], expLen[4], actPat[4], actLen[4];
    logic [3:0] cur;
    bit ok;
    decayMode = 2'(mode);
    offTime   = 8'(off);
    idx = 0;
    guard = 0;
    forever begin
      if (idx == tripAt) senseIn = 10'd500;  // exactly at threshold (R4)
      @(negedge clk);
      guard++;
      if (gatesNow() != onPat(pol) || guard > 2000) break;
      idx++;
    end
    senseIn = 10'd100;
    expOn = ((blankCur > tripAt) ? blankCur : tripAt) + 1;
    check(idx + 1 == expOn, "R3 drive length", idx + 1, expOn);
    // R11: change sampled inputs after the trip has been accepted
    blankTime = 8'(newBlank);
    polarity  = newPol;
    decayMode = 2'($urandom % 4);
    offTime   = 8'($urandom % 50);
    // collect run lengths until the next drive pattern
    nAct = 0;
    cur = gatesNow();
    len = 1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (gatesNow() == onPat(newPol) || guard > 3000) break;
      if (gatesNow() == cur) len++;
      else begin
        if (nAct < 4) begin actPat[nAct] = int'(cur); actLen[nAct] = len; end
        nAct++;
        cur = gatesNow();
        len = 1;
      end
    end
    if (nAct < 4) begin actPat[nAct] = int'(cur); actLen[nAct] = len; end
    nAct++;
    offEff = (off == 0) ? 1 : off;
    fl = (offEff * FRAC) >> 8;
    if (mode == 1) begin
      nExp = 1; expPat[0] = 0; expLen[0] = offEff + DEAD;
    end else if (mode == 2 && fl > 0) begin
      nExp = 3;
      expPat[0] = 0; expLen[0] = fl;
      expPat[1] = int'(sinkPat(pol)); expLen[1] = offEff - fl;
      expPat[2] = 0; expLen[2] = DEAD;
    end else begin
      nExp = 2;
      expPat[0] = int'(sinkPat(pol)); expLen[0] = offEff;
      expPat[1] = 0; expLen[1] = DEAD;
    end
    ok = (nAct == nExp);
    for (int k = 0; k < 4; k++)
      if (ok && k < nExp) ok = (actPat[k] == expPat[k]) && (actLen[k] == expLen[k]);
    if (mode == 1)
      check(ok, $sformatf("R6/R8 fast off sequence it=%0d runs", it), nAct, nExp);
    else if (mode == 2)
      check(ok, $sformatf("R7/R8 mixed off sequence it=%0d runs", it), nAct, nExp);
    else
      check(ok, $sformatf("R5/R8 slow off sequence it=%0d runs", it), nAct, nExp);
    if (!ok)
      $display("  first run act pat=%0d len=%0d exp pat=%0d len=%0d",
               actPat[0], actLen[0], expPat[0], expLen[0]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int zeros, pct, mx, blankCur, mode, off, tripAt, nb;
    logic pol, np;
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check(gatesNow() == 4'b0000, "R1 gates during reset", int'(gatesNow()), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(gatesNow() == 4'b0000, "R1 gates idle after reset", int'(gatesNow()), 0);

    // R4 threshold: directed then random
    levelPct = 7'd100; tripMax = 10'd1023; #1;
    check(int'(tripThreshold) == 1023, "R4 threshold 100%", int'(tripThreshold), 1023);
    levelPct = 7'd127; tripMax = 10'd777; #1;
    check(int'(tripThreshold) == 777, "R4 threshold clamp", int'(tripThreshold), 777);
    levelPct = 7'd0; #1;
    check(int'(tripThreshold) == 0, "R4 threshold zero", int'(tripThreshold), 0);
    for (int i = 0; i < 20; i++) begin
      pct = int'($urandom % 128);
      mx  = int'($urandom % 1024);
      levelPct = 7'(pct); tripMax = 10'(mx); #1;
      check(int'(tripThreshold) == expThr(pct, mx), "R4 threshold random",
            int'(tripThreshold), expThr(pct, mx));
    end
    levelPct = 7'd50; tripMax = 10'd1000; senseIn = 10'd100;

    // R2 start-up
    @(negedge clk);
    enable = 1'b1; polarity = 1'b0; blankTime = 8'd3;
    countZeros(zeros);
    check(zeros == DEAD, "R2 dead cycles after enable", zeros, DEAD);
    check(gatesNow() == onPat(0), "R2 drive pattern polarity 0", int'(gatesNow()), int'(onPat(0)));

    // R4 sense one below threshold keeps drive on
    senseIn = 10'd499;
    repeat (8) @(negedge clk);
    check(gatesNow() == onPat(0), "R4 below threshold stays on", int'(gatesNow()), int'(onPat(0)));
    senseIn = 10'd100;

    // R9 polarity change during drive, then during dead
    polarity = 1'b1;
    countZeros(zeros);
    check(zeros == DEAD, "R9 dead after polarity change in drive", zeros, DEAD);
    check(gatesNow() == onPat(1), "R9 drive polarity 1", int'(gatesNow()), int'(onPat(1)));
    polarity = 1'b0;
    @(negedge clk);
    @(negedge clk);
    polarity = 1'b1;
    countZeros(zeros);
    check(zeros == DEAD, "R9 dead restarts on change in dead", zeros + 0, DEAD);
    check(gatesNow() == onPat(1), "R9 drive after restart", int'(gatesNow()), int'(onPat(1)));

    // chopping periods: directed corners first, then random (R3, R5-R8, R9, R11)
    pol = 1'b1;
    blankCur = 3;
    for (int it = 0; it < 40; it++) begin
      case (it)
        0: begin mode = 0; off = 0; end
        1: begin mode = 1; off = 1; end
        2: begin mode = 2; off = 200; end
        3: begin mode = 2; off = 3; end
        4: begin mode = 3; off = 7; end
        default: begin mode = int'($urandom % 4); off = int'($urandom % 40); end
      endcase
      tripAt = int'($urandom % 7);
      nb = int'($urandom % 6);
      np = 1'($urandom % 2);
      runPeriod(it, pol, blankCur, mode, off, tripAt, nb, np);
      pol = np;
      blankCur = nb;
    end

    // R1 disable during drive
    enable = 1'b0;
    @(negedge clk);
    check(gatesNow() == 4'b0000, "R1 disable forces off", int'(gatesNow()), 0);
    repeat (5) @(negedge clk);
    check(gatesNow() == 4'b0000, "R1 stays off while disabled", int'(gatesNow()), 0);
    enable = 1'b1;
    countZeros(zeros);
    check(zeros == DEAD, "R2 dead cycles on re-enable", zeros, DEAD);

    check(legViol == 0, "R10 leg overlap samples", legViol, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule